// File: doc/BRIEF.md
# Byte-Wide Synchronous Serial Port

This block moves one byte at a time over a four-wire synchronous serial link and can play either end of it. With the role input high it is the clock master. It makes the serial clock from the system clock through a programmable divider, and a write of the data buffer starts an eight-bit full-duplex exchange at once. With the role input low it is a slave. It then shifts only when the externally supplied serial clock moves, and it samples that clock and the incoming data line through a synchroniser.

Transmit data has a single buffer: a buffer write goes straight into the shift register. Receive data has two buffers. A finished byte is copied into a holding register that the host reads at its own pace, and a completion flag is raised. If a byte completes while the previous one is still flagged, the new byte replaces the old one and a sticky overrun bit is set. When the output-drive enable is low, a master keeps clocking on its own and captures one byte after another. In that mode the port serves as a passive line monitor.

Top module: `ssp_shift_port`

## Requirements
- R1: In master role, a buffer write accepted while idle raises `busy` on the next clock edge and puts bit 7 of the written byte on `sdo`. No other start command exists.
- R2: Bits travel MSB first. The receiver samples on the leading serial-clock edge (idle level to active level) and the transmitter changes `sdo` only on the trailing edge. One transfer is exactly 8 serial-clock cycles.
- R3: Transfers are full duplex. After the eighth trailing edge, `rd_data` holds the eight bits sampled from `sdi`, MSB first, and `done_flag` is 1.
- R4: In master role, each half-period of `sck_out` lasts `clk_div` system clocks, and a `clk_div` of 0 acts as 1. While idle, `sck_out` rests at the `cpol` level.
- R5: A buffer write that arrives while `busy` is 1 is ignored. The byte in flight is transmitted unchanged and no extra transfer follows.
- R6: When a byte completes while `done_flag` is still 1, `rd_data` is overwritten and `overrun` is set. A `done_clr` pulse returns both `done_flag` and `overrun` to 0.
- R7: In slave role, the port shifts only on edges of `sck_in` (leading and trailing defined against `cpol` in the same way as in R2). A buffer write with no `sck_in` activity never completes a transfer.
- R8: In master role with `sdo_en` low, `sdo_oe` is 0. The port then runs back-to-back transfers without any buffer write, and each byte completes with the normal flag. Once `sdo_en` goes high, the byte in progress finishes and the port stops.
- R9: After reset, `done_flag`, `overrun`, `busy`, `rd_data` and `sck_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 selects master role, 0 selects slave role |
| cpol | input | 1 | Idle level of the serial clock |
| clk_div | input | DIV_W | System clocks per serial-clock half-period (master) |
| wr_stb | input | 1 | Buffer write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| rd_data | output | DATA_W | Last received byte |
| done_flag | output | 1 | Sticky completion flag |
| done_clr | input | 1 | Clears `done_flag` and `overrun` |
| overrun | output | 1 | Sticky receive overwrite indicator |
| sck_in | input | 1 | External serial clock (slave) |
| sck_out | output | 1 | Generated serial clock (master) |
| sck_oe | output | 1 | Drive enable for `sck_out` |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | input | 1 | Enables driving `sdo`; low in master role selects monitor mode |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| busy | output | 1 | A transfer is in progress |

## Verification
A bit counter that is off by one shows on the ports within one byte. The completion flag then rises a serial-clock cycle early or late, and the captured byte appears rotated against the bits the bench drove on `sdi`. A shift register that moves on the wrong edge makes `sdo` change while the serial clock is at its active level, and this is caught in that same half-period. A divider or run-state fault changes the spacing of `sck_out` toggles or leaves the clock off its idle level between transfers, so it is seen at the first toggle or at the first idle cycle. A wrong overrun or flag state is exposed at the next completion or clear, through `overrun` and `rd_data`.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int SSP_DATA_W = 8;
    localparam int SSP_DIV_W  = 8;
    localparam int SSP_SYNC_N = 2;

    // One-cycle serial clock events seen by the shift core
    typedef struct packed {
        logic lead;   // idle level -> active level
        logic trail;  // active level -> idle level
    } sck_evt_t;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // Terminal count for a half-period counter; a zero divider behaves as one
    function automatic logic [31:0] half_limit(input logic [31:0] div);
        return (div == 32'd0) ? 32'd0 : div - 32'd1;
    endfunction

endpackage

// File: rtl/ssp_master_clk.sv
module ssp_master_clk #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W,
    parameter int DIV_W  = ssp_pkg::SSP_DIV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                cpol,
    input  logic [DIV_W-1:0]    div,
    input  logic                start,
    input  logic                free_run,
    output logic                sck,
    output ssp_pkg::sck_evt_t   evt,
    output logic                running
);
    import ssp_pkg::*;

    localparam int TOGGLES = 2 * DATA_W;
    localparam int TW      = $clog2(TOGGLES);
    localparam logic [TW-1:0] LAST_TOG = TW'(TOGGLES - 1);

    logic [DIV_W-1:0] hcnt;
    logic [DIV_W-1:0] lim;
    logic [TW-1:0]    tog;
    logic             run_q;
    logic             sck_q;
    logic             tick;

    assign lim  = DIV_W'(half_limit(32'(div)));
    assign tick = run_q && enable && (hcnt == lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            sck_q <= 1'b0;
            hcnt  <= '0;
            tog   <= '0;
        end else if (!run_q) begin
            hcnt  <= '0;
            tog   <= '0;
            sck_q <= cpol;
            if (enable && (start || free_run))
                run_q <= 1'b1;
        end else if (!enable) begin
            run_q <= 1'b0;
            sck_q <= cpol;
        end else if (tick) begin
            hcnt  <= '0;
            sck_q <= ~sck_q;
            if (tog == LAST_TOG) begin
                tog <= '0;
                if (!free_run)
                    run_q <= 1'b0;
            end else begin
                tog <= tog + 1'b1;
            end
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    always_comb begin
        evt.lead  = tick && !tog[0];
        evt.trail = tick &&  tog[0];
    end

    assign sck     = sck_q;
    assign running = run_q;

endmodule

// File: rtl/ssp_slave_edge.sv
module ssp_slave_edge #(
    parameter int SYNC_N = ssp_pkg::SSP_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              cpol,
    input  logic              sck_raw,
    input  logic              sdi_raw,
    output logic              sdi_sync,
    output ssp_pkg::sck_evt_t evt
);
    import ssp_pkg::*;

    logic [SYNC_N-1:0] sck_pipe;
    logic [SYNC_N-1:0] sdi_pipe;
    logic              sck_prev;
    logic              sck_s;

    // Synchroniser stages, first stage from the pin
    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sck_pipe[g] <= 1'b0;
                        sdi_pipe[g] <= 1'b0;
                    end else begin
                        sck_pipe[g] <= sck_raw;
                        sdi_pipe[g] <= sdi_raw;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) begin
                        sck_pipe[g] <= 1'b0;
                        sdi_pipe[g] <= 1'b0;
                    end else begin
                        sck_pipe[g] <= sck_pipe[g-1];
                        sdi_pipe[g] <= sdi_pipe[g-1];
                    end
                end
            end
        end
    endgenerate

    assign sck_s    = sck_pipe[SYNC_N-1];
    assign sdi_sync = sdi_pipe[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst)
            sck_prev <= 1'b0;
        else
            sck_prev <= sck_s;
    end

    always_comb begin
        evt.lead  = enable && (sck_s != sck_prev) && (sck_s != cpol);
        evt.trail = enable && (sck_s != sck_prev) && (sck_s == cpol);
    end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ssp_pkg::sck_evt_t evt,
    input  logic              sdi_bit,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              sdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    import ssp_pkg::*;

    localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);

    logic [DATA_W-1:0] sh;
    logic [CW-1:0]     cnt;
    logic              cap;
    logic              phase;
    logic              shift_now;

    assign shift_now = evt.trail && phase;
    assign rx_byte   = {sh[DATA_W-2:0], cap};
    assign done      = shift_now && (cnt == LAST_BIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            cnt   <= '0;
            cap   <= 1'b0;
            phase <= 1'b0;
        end else if (load) begin
            sh    <= load_data;
            cnt   <= '0;
            phase <= 1'b0;
        end else if (evt.lead) begin
            cap   <= sdi_bit;
            phase <= 1'b1;
        end else if (shift_now) begin
            sh    <= rx_byte;
            phase <= 1'b0;
            cnt   <= (cnt == LAST_BIT) ? '0 : cnt + 1'b1;
        end
    end

    assign sdo  = sh[DATA_W-1];
    assign busy = phase || (cnt != '0);

endmodule

// File: rtl/ssp_rx_hold.sv
module ssp_rx_hold #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              clr,
    output logic [DATA_W-1:0] held,
    output logic              flag,
    output logic              ovr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            flag <= 1'b0;
            ovr  <= 1'b0;
        end else if (done) begin
            held <= rx_byte;
            flag <= 1'b1;
            ovr  <= clr ? 1'b0 : (ovr | flag);
        end else if (clr) begin
            flag <= 1'b0;
            ovr  <= 1'b0;
        end
    end
endmodule

// File: rtl/ssp_shift_port.sv
module ssp_shift_port #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W,
    parameter int DIV_W  = ssp_pkg::SSP_DIV_W,
    parameter int SYNC_N = ssp_pkg::SSP_SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              is_master,
    input  logic              cpol,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              done_flag,
    input  logic              done_clr,
    output logic              overrun,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    input  logic              sdo_en,
    output logic              sdo_oe,
    output logic              busy
);
    import ssp_pkg::*;

    role_e             role;
    sck_evt_t          m_evt;
    sck_evt_t          s_evt;
    sck_evt_t          core_evt;
    logic              m_running;
    logic              core_busy;
    logic              core_done;
    logic [DATA_W-1:0] core_rx;
    logic              sdi_sync;
    logic              sdi_core;
    logic              accept_wr;

    assign role      = is_master ? ROLE_MASTER : ROLE_SLAVE;
    assign busy      = (role == ROLE_MASTER) ? m_running : core_busy;
    assign accept_wr = wr_stb && !busy;

    ssp_master_clk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_mclk (
        .clk      (clk),
        .rst      (rst),
        .enable   (role == ROLE_MASTER),
        .cpol     (cpol),
        .div      (clk_div),
        .start    (accept_wr),
        .free_run (!sdo_en),
        .sck      (sck_out),
        .evt      (m_evt),
        .running  (m_running)
    );

    ssp_slave_edge #(.SYNC_N(SYNC_N)) u_sedge (
        .clk      (clk),
        .rst      (rst),
        .enable   (role == ROLE_SLAVE),
        .cpol     (cpol),
        .sck_raw  (sck_in),
        .sdi_raw  (sdi),
        .sdi_sync (sdi_sync),
        .evt      (s_evt)
    );

    assign core_evt = (role == ROLE_MASTER) ? m_evt : s_evt;
    assign sdi_core = (role == ROLE_MASTER) ? sdi : sdi_sync;

    ssp_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .evt       (core_evt),
        .sdi_bit   (sdi_core),
        .load      (accept_wr),
        .load_data (wr_data),
        .sdo       (sdo),
        .busy      (core_busy),
        .done      (core_done),
        .rx_byte   (core_rx)
    );

    ssp_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .done    (core_done),
        .rx_byte (core_rx),
        .clr     (done_clr),
        .held    (rd_data),
        .flag    (done_flag),
        .ovr     (overrun)
    );

    assign sck_oe = (role == ROLE_MASTER);
    assign sdo_oe = sdo_en;

endmodule

// File: rtl/ssp_shift_port_chk.sv
module ssp_shift_port_chk #(
    parameter int DATA_W = ssp_pkg::SSP_DATA_W
) (
    input logic              clk,
    input logic              rst,
    input logic              is_master,
    input logic              cpol,
    input logic              busy,
    input logic              sck_out,
    input logic              sdo,
    input logic              done_flag,
    input logic              overrun,
    input logic [DATA_W-1:0] rd_data
);
    // R4
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && is_master && !busy && $past(!busy) && $stable(cpol))
        |-> (sck_out == cpol));

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && is_master && busy && $stable(cpol)
         && (sck_out != cpol) && $past(sck_out != cpol))
        |-> $stable(sdo));

    // R6
    overrun_flag_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> done_flag);

    // R3
    rx_update_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$stable(rd_data)) |-> done_flag);

endmodule

bind ssp_shift_port ssp_shift_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .is_master (is_master),
    .cpol      (cpol),
    .busy      (busy),
    .sck_out   (sck_out),
    .sdo       (sdo),
    .done_flag (done_flag),
    .overrun   (overrun),
    .rd_data   (rd_data)
);

// File: tb/sim_ssp_shift_port.sv
module sim_ssp_shift_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       is_master = 1'b1;
    logic       cpol = 1'b0;
    logic [7:0] clk_div = 8'd2;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       done_flag;
    logic       done_clr = 1'b0;
    logic       overrun;
    logic       sck_in = 1'b0;
    logic       sck_out;
    logic       sck_oe;
    logic       sdi = 1'b0;
    logic       sdo;
    logic       sdo_en = 1'b1;
    logic       sdo_oe;
    logic       busy;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ssp_shift_port u0 (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard: expected received bytes, popped on each flag rise
    logic [7:0] exp_q[$];
    bit         auto_clr = 1'b1;
    logic       prev_flag = 1'b0;
    int         ncomp = 0;

    always @(negedge clk) begin
        if (!rst && done_flag && !prev_flag) begin
            ncomp++;
            if (exp_q.size() == 0)
                chk(1'b0, "R3 unexpected byte", int'(rd_data), 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R3 received byte", int'(rd_data), int'(e));
            end
        end
        prev_flag = done_flag;
        if (auto_clr) done_clr = done_flag;
    end

    // Remote slave model for master-role tests
    logic       prev_sck = 1'b0;
    logic       prev_busy = 1'b0;
    int         gap = 0;
    int         last_gap = 0;
    int         lead_n = 0;
    int         trail_n = 0;
    logic [7:0] cap = 8'h00;
    logic [7:0] mst_cap = 8'h00;
    logic [7:0] slv_cur = 8'h00;
    logic [7:0] slv_q[$];

    always @(negedge clk) begin
        if (!rst && is_master) begin
            gap++;
            if ((sck_out != prev_sck) && (busy || prev_busy)) begin
                last_gap = gap;
                gap = 0;
                if (sck_out != cpol) begin
                    cap = {cap[6:0], sdo};
                    lead_n++;
                    if (lead_n % 8 == 0) mst_cap = cap;
                end else begin
                    trail_n++;
                    if (trail_n % 8 == 0)
                        slv_cur = (slv_q.size() != 0) ? slv_q.pop_front() : 8'h00;
                    else
                        slv_cur = {slv_cur[6:0], 1'b0};
                    sdi = slv_cur[7];
                end
            end
        end
        prev_sck  = sck_out;
        prev_busy = busy;
    end

    task automatic wait_idle();
        for (int n = 0; n < 5000 && busy; n++) @(negedge clk);
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx, input bit push);
        wait_idle();
        @(negedge clk);
        slv_cur = rx;
        sdi = rx[7];
        lead_n = 0;
        trail_n = 0;
        if (push) exp_q.push_back(rx);
        wr_data = tx;
        wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        chk(busy == 1'b1, "R1 busy after write", int'(busy), 1);
        chk(sdo == tx[7], "R1 msb presented", int'(sdo), int'(tx[7]));
        wait_idle();
        repeat (3) @(negedge clk);
        chk(mst_cap == tx, "R2 bits seen on sdo", int'(mst_cap), int'(tx));
    endtask

    task automatic slave_xfer(input logic [7:0] mosi, input logic [7:0] miso);
        logic [7:0] scap;
        scap = 8'h00;
        exp_q.push_back(mosi);
        for (int i = 7; i >= 0; i--) begin
            sdi = mosi[i];
            repeat (7) @(negedge clk);
            scap = {scap[6:0], sdo};
            sck_in = ~cpol;
            repeat (7) @(negedge clk);
            sck_in = cpol;
        end
        repeat (8) @(negedge clk);
        chk(scap == miso, "R7 slave sdo byte", int'(scap), int'(miso));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(done_flag == 1'b0, "R9 flag", int'(done_flag), 0);
        chk(overrun == 1'b0, "R9 overrun", int'(overrun), 0);
        chk(busy == 1'b0, "R9 busy", int'(busy), 0);
        chk(rd_data == 8'h00, "R9 rd_data", int'(rd_data), 0);
        chk(sck_out == 1'b0, "R9 sck_out", int'(sck_out), 0);

        // R1 R2 R3 master, cpol 0, divider 2
        master_xfer(8'hA5, 8'h3C, 1'b1);
        chk(last_gap == 2, "R4 half period div 2", last_gap, 2);
        master_xfer(8'h81, 8'hFE, 1'b1);
        clk_div = 8'd3;
        master_xfer(8'h5A, 8'h01, 1'b1);
        chk(last_gap == 3, "R4 half period div 3", last_gap, 3);

        // R4 idle level follows cpol, zero divider acts as one
        cpol = 1'b1;
        clk_div = 8'd0;
        repeat (3) @(negedge clk);
        chk(sck_out == 1'b1, "R4 idle at cpol 1", int'(sck_out), 1);
        master_xfer(8'hC3, 8'h96, 1'b1);
        chk(last_gap == 1, "R4 half period div 0", last_gap, 1);
        chk(sck_out == 1'b1, "R4 back to idle", int'(sck_out), 1);
        cpol = 1'b0;
        clk_div = 8'd2;
        repeat (3) @(negedge clk);

        // R5 write while busy is ignored
        base = ncomp;
        @(negedge clk);
        slv_cur = 8'h77; sdi = 1'b0; lead_n = 0; trail_n = 0;
        exp_q.push_back(8'h77);
        wr_data = 8'h4B; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (9) @(negedge clk);
        wr_data = 8'hFF; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(mst_cap == 8'h4B, "R5 first byte kept", int'(mst_cap), 8'h4B);
        chk(ncomp == base + 1, "R5 one completion", ncomp, base + 1);
        chk(busy == 1'b0, "R5 no extra transfer", int'(busy), 0);

        // R6 overrun
        auto_clr = 1'b0;
        done_clr = 1'b0;
        master_xfer(8'h11, 8'h22, 1'b1);
        master_xfer(8'h33, 8'h44, 1'b0);
        chk(overrun == 1'b1, "R6 overrun set", int'(overrun), 1);
        chk(rd_data == 8'h44, "R6 newer byte kept", int'(rd_data), 8'h44);
        chk(done_flag == 1'b1, "R6 flag still set", int'(done_flag), 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(done_flag == 1'b0, "R6 flag cleared", int'(done_flag), 0);
        chk(overrun == 1'b0, "R6 overrun cleared", int'(overrun), 0);
        prev_flag = 1'b0;
        auto_clr = 1'b1;

        // R8 monitor mode: continuous capture without writes
        is_master = 1'b0;
        repeat (3) @(negedge clk);
        base = ncomp;
        slv_cur = 8'hB1; sdi = 1'b1;
        lead_n = 0; trail_n = 0;
        slv_q = '{8'h62, 8'h0F, 8'hE4, 8'h9D};
        exp_q = '{8'hB1, 8'h62, 8'h0F, 8'hE4, 8'h9D};
        sdo_en = 1'b0;
        is_master = 1'b1;
        @(negedge clk);
        chk(sdo_oe == 1'b0, "R8 sdo not driven", int'(sdo_oe), 0);
        for (int n = 0; n < 5000 && ncomp < base + 4; n++) @(negedge clk);
        sdo_en = 1'b1;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(ncomp == base + 5, "R8 bytes captured", ncomp, base + 5);
        chk(exp_q.size() == 0, "R8 stream drained", exp_q.size(), 0);

        // R7 slave role
        is_master = 1'b0;
        cpol = 1'b0;
        sck_in = 1'b0;
        repeat (6) @(negedge clk);
        base = ncomp;
        wr_data = 8'hD2; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        repeat (60) @(negedge clk);
        chk(ncomp == base, "R7 no shift without sck_in", ncomp, base);
        chk(done_flag == 1'b0, "R7 no flag without sck_in", int'(done_flag), 0);
        slave_xfer(8'h6E, 8'hD2);
        chk(ncomp == base + 1, "R7 slave completion", ncomp, base + 1);

        // R7 slave with idle-high clock
        cpol = 1'b1;
        sck_in = 1'b1;
        repeat (8) @(negedge clk);
        wr_data = 8'h39; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        slave_xfer(8'hA7, 8'h39);
        chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule